// File: doc/BRIEF.md
# Pipeline Hazard Controller with Global Memory Stall

This block steers hazard handling for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It watches the register addresses held in each stage. From them it chooses a bypass source for each of the two execute-stage operands. It holds the front of the pipeline when an instruction in decode needs a value that a load in execute has not yet produced. It also discards the wrong-path instructions behind a taken branch or jump.

A memory-side stall request is also folded in. The request is raised when the data cache reports a miss or when the backing memory is not ready. It freezes the program counter and all four pipeline registers together, and it suppresses every clear so that no instruction is dropped while memory catches up. The block is purely combinational. Every output is a function of the current inputs and is used by the datapath's registers at the next clock edge.

Top module: `hazard_ctrl`

## Requirements
- R1: An execute-stage source address that equals a nonzero memory-stage destination with `we_m_i` high gets forward select 2'b10 (memory-stage result).
- R2: An execute-stage source address that equals a nonzero writeback-stage destination with `we_w_i` high, and has no memory-stage match, gets forward select 2'b01 (writeback result).
- R3: When the memory and writeback stages both match the same source, the memory stage wins (select 2'b10).
- R4: Register address 0 never matches, neither for forwarding (select stays 2'b00) nor for the load-use check.
- R5: A destination whose write enable is low is never forwarded; the select is 2'b00 (register file).
- R6: A load in execute whose nonzero destination equals either decode source drives `en_pc_o` and `en_fd_o` low and `clr_de_o` high, with `en_de_o`, `en_em_o` and `en_mw_o` high.
- R7: The same address match without the load flag causes no stall and no clear.
- R8: A taken branch or jump drives both `clr_fd_o` and `clr_de_o` high, and all enables stay high.
- R9: When `cache_hit_i` is low or `mem_ready_i` is low, all five enables are low.
- R10: While the global stall is active, `clr_fd_o` and `clr_de_o` stay low, even with a taken branch or a load-use hazard present.
- R11: With no hazard and no memory stall, all enables are high, both clears are low and both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_d_i | input | 5 | First source address in decode |
| rs2_d_i | input | 5 | Second source address in decode |
| rs1_e_i | input | 5 | First source address in execute |
| rs2_e_i | input | 5 | Second source address in execute |
| rd_e_i | input | 5 | Destination address in execute |
| rd_m_i | input | 5 | Destination address in memory stage |
| rd_w_i | input | 5 | Destination address in writeback |
| we_m_i | input | 1 | Memory-stage instruction writes a register |
| we_w_i | input | 1 | Writeback-stage instruction writes a register |
| load_e_i | input | 1 | Execute-stage instruction is a load |
| taken_e_i | input | 1 | Branch or jump in execute is taken |
| cache_hit_i | input | 1 | Data cache hit (low requests global stall) |
| mem_ready_i | input | 1 | Backing memory ready (low requests global stall) |
| fwd_a_o | output | 2 | Forward select, operand A (00 regfile, 01 writeback, 10 memory) |
| fwd_b_o | output | 2 | Forward select, operand B (same encoding) |
| en_pc_o | output | 1 | Program counter enable |
| en_fd_o | output | 1 | Fetch/decode register enable |
| en_de_o | output | 1 | Decode/execute register enable |
| en_em_o | output | 1 | Execute/memory register enable |
| en_mw_o | output | 1 | Memory/writeback register enable |
| clr_fd_o | output | 1 | Fetch/decode register clear |
| clr_de_o | output | 1 | Decode/execute register clear |

## Verification
Every output is combinational, so each result is due in the same cycle as the stimulus that causes it, with no register in the path. The bench changes inputs just after a falling clock edge and samples one nanosecond later. The outputs have settled by then, and the sample is taken well before the next rising edge. Each scenario also returns the inputs to the idle pattern, so a result cannot carry over into the next check.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned NS = NUM_SRC
) (
  input  logic [NS-1:0][AW-1:0] rs_e_i,
  input  logic [AW-1:0]         rd_m_i,
  input  logic [AW-1:0]         rd_w_i,
  input  logic                  we_m_i,
  input  logic                  we_w_i,
  output logic [NS-1:0][1:0]    sel_o
);
  localparam logic [AW-1:0] ZERO = '0;

  for (genvar g = 0; g < NS; g++) begin : g_src
    logic hit_m, hit_w;
    assign hit_m = we_m_i && (rd_m_i != ZERO) && (rd_m_i == rs_e_i[g]);
    assign hit_w = we_w_i && (rd_w_i != ZERO) && (rd_w_i == rs_e_i[g]);

    always_comb begin
      // memory stage holds the younger result
      if (hit_m)      sel_o[g] = FWD_MEM;
      else if (hit_w) sel_o[g] = FWD_WB;
      else            sel_o[g] = FWD_RF;
    end

    always_comb begin
      if (rs_e_i[g] == ZERO)
        assert_x0_no_fwd_R4: assert (sel_o[g] == FWD_RF)
          else $error("x0 forwarded");
      if (!we_m_i && !we_w_i)
        assert_we_gate_R5: assert (sel_o[g] == FWD_RF)
          else $error("forward without write enable");
    end
  end
endmodule

// File: rtl/hz_loaduse_unit.sv
module hz_loaduse_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned NS = NUM_SRC
) (
  input  logic [NS-1:0][AW-1:0] rs_d_i,
  input  logic [AW-1:0]         rd_e_i,
  input  logic                  load_e_i,
  output logic                  hazard_o
);
  localparam logic [AW-1:0] ZERO = '0;

  logic [NS-1:0] match;
  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign match[g] = (rs_d_i[g] == rd_e_i);
  end

  assign hazard_o = load_e_i && (rd_e_i != ZERO) && (|match);

  always_comb begin
    if (!load_e_i)
      assert_load_only_R7: assert (!hazard_o) else $error("stall without load");
  end
endmodule

// File: rtl/hz_ctrl_merge.sv
module hz_ctrl_merge (
  input  logic lu_hazard_i,
  input  logic taken_i,
  input  logic cache_hit_i,
  input  logic mem_ready_i,
  output logic en_pc_o,
  output logic en_fd_o,
  output logic en_de_o,
  output logic en_em_o,
  output logic en_mw_o,
  output logic clr_fd_o,
  output logic clr_de_o
);
  logic gstall, front_hold;

  assign gstall     = !cache_hit_i || !mem_ready_i;
  assign front_hold = gstall || lu_hazard_i;

  assign en_pc_o = !front_hold;
  assign en_fd_o = !front_hold;
  assign en_de_o = !gstall;
  assign en_em_o = !gstall;
  assign en_mw_o = !gstall;

  // a frozen pipe must not drop anything
  assign clr_fd_o = !gstall && taken_i;
  assign clr_de_o = !gstall && (taken_i || lu_hazard_i);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
(
  input  logic [4:0] rs1_d_i,
  input  logic [4:0] rs2_d_i,
  input  logic [4:0] rs1_e_i,
  input  logic [4:0] rs2_e_i,
  input  logic [4:0] rd_e_i,
  input  logic [4:0] rd_m_i,
  input  logic [4:0] rd_w_i,
  input  logic       we_m_i,
  input  logic       we_w_i,
  input  logic       load_e_i,
  input  logic       taken_e_i,
  input  logic       cache_hit_i,
  input  logic       mem_ready_i,
  output logic [1:0] fwd_a_o,
  output logic [1:0] fwd_b_o,
  output logic       en_pc_o,
  output logic       en_fd_o,
  output logic       en_de_o,
  output logic       en_em_o,
  output logic       en_mw_o,
  output logic       clr_fd_o,
  output logic       clr_de_o
);
  logic [NUM_SRC-1:0][REG_AW-1:0] rs_e, rs_d;
  logic [NUM_SRC-1:0][1:0]        sel;
  logic                           lu_hazard;

  assign rs_e = {rs2_e_i, rs1_e_i};
  assign rs_d = {rs2_d_i, rs1_d_i};

  hz_fwd_unit #(.AW(REG_AW), .NS(NUM_SRC)) u_fwd (
    .rs_e_i (rs_e),
    .rd_m_i (rd_m_i),
    .rd_w_i (rd_w_i),
    .we_m_i (we_m_i),
    .we_w_i (we_w_i),
    .sel_o  (sel)
  );

  hz_loaduse_unit #(.AW(REG_AW), .NS(NUM_SRC)) u_lu (
    .rs_d_i   (rs_d),
    .rd_e_i   (rd_e_i),
    .load_e_i (load_e_i),
    .hazard_o (lu_hazard)
  );

  hz_ctrl_merge u_merge (
    .lu_hazard_i (lu_hazard),
    .taken_i     (taken_e_i),
    .cache_hit_i (cache_hit_i),
    .mem_ready_i (mem_ready_i),
    .en_pc_o     (en_pc_o),
    .en_fd_o     (en_fd_o),
    .en_de_o     (en_de_o),
    .en_em_o     (en_em_o),
    .en_mw_o     (en_mw_o),
    .clr_fd_o    (clr_fd_o),
    .clr_de_o    (clr_de_o)
  );

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  always_comb begin
    if (!cache_hit_i || !mem_ready_i)
      assert_gstall_all_R9: assert (!en_pc_o && !en_fd_o && !en_de_o && !en_em_o && !en_mw_o)
        else $error("global stall left a register enabled");
    if (!en_mw_o)
      assert_no_clr_frozen_R10: assert (!clr_fd_o && !clr_de_o)
        else $error("clear during global stall");
    if (!en_fd_o && en_de_o)
      assert_bubble_R6: assert (clr_de_o && !en_pc_o)
        else $error("front stall without bubble");
    if (clr_fd_o)
      assert_flush_pair_R8: assert (clr_de_o && taken_e_i)
        else $error("decode clear without taken branch");
  end
endmodule

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] rs1_d, rs2_d, rs1_e, rs2_e, rd_e, rd_m, rd_w;
  logic we_m, we_w, load_e, taken_e, cache_hit, mem_ready;
  logic [1:0] fwd_a, fwd_b;
  logic en_pc, en_fd, en_de, en_em, en_mw, clr_fd, clr_de;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hazard_ctrl u0 (
    .rs1_d_i(rs1_d), .rs2_d_i(rs2_d), .rs1_e_i(rs1_e), .rs2_e_i(rs2_e),
    .rd_e_i(rd_e), .rd_m_i(rd_m), .rd_w_i(rd_w),
    .we_m_i(we_m), .we_w_i(we_w), .load_e_i(load_e), .taken_e_i(taken_e),
    .cache_hit_i(cache_hit), .mem_ready_i(mem_ready),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .en_pc_o(en_pc), .en_fd_o(en_fd), .en_de_o(en_de), .en_em_o(en_em), .en_mw_o(en_mw),
    .clr_fd_o(clr_fd), .clr_de_o(clr_de)
  );

  // {fwd_a, fwd_b, en_pc, en_fd, en_de, en_em, en_mw, clr_fd, clr_de}
  localparam logic [10:0] IDLE = {2'b00, 2'b00, 5'b11111, 2'b00};

  function automatic logic [10:0] obs();
    return {fwd_a, fwd_b, en_pc, en_fd, en_de, en_em, en_mw, clr_fd, clr_de};
  endfunction

  task automatic idle_in();
    rs1_d = 5'd1; rs2_d = 5'd2; rs1_e = 5'd3; rs2_e = 5'd4;
    rd_e = 5'd10; rd_m = 5'd11; rd_w = 5'd12;
    we_m = 1'b0; we_w = 1'b0; load_e = 1'b0; taken_e = 1'b0;
    cache_hit = 1'b1; mem_ready = 1'b1;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [10:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, obs(), exp);
    end
  endtask

  task automatic t_idle_R11();
    idle_in(); settle();
    chk("R11", IDLE);
  endtask

  task automatic t_mem_fwd_R1();
    idle_in(); rs1_e = 5'd5; rd_m = 5'd5; we_m = 1'b1; settle();
    chk("R1", {2'b10, 2'b00, 5'b11111, 2'b00});
    idle_in(); rs2_e = 5'd31; rd_m = 5'd31; we_m = 1'b1; settle();
    chk("R1", {2'b00, 2'b10, 5'b11111, 2'b00});
  endtask

  task automatic t_wb_fwd_R2();
    idle_in(); rs2_e = 5'd9; rd_w = 5'd9; we_w = 1'b1; settle();
    chk("R2", {2'b00, 2'b01, 5'b11111, 2'b00});
    idle_in(); rs1_e = 5'd7; rs2_e = 5'd7; rd_w = 5'd7; we_w = 1'b1; settle();
    chk("R2", {2'b01, 2'b01, 5'b11111, 2'b00});
  endtask

  task automatic t_prio_R3();
    idle_in(); rs1_e = 5'd6; rs2_e = 5'd8; rd_m = 5'd6; rd_w = 5'd6;
    we_m = 1'b1; we_w = 1'b1; settle();
    chk("R3", {2'b10, 2'b00, 5'b11111, 2'b00});
  endtask

  task automatic t_x0_R4();
    idle_in(); rs1_e = 5'd0; rs2_e = 5'd0; rd_m = 5'd0; rd_w = 5'd0;
    we_m = 1'b1; we_w = 1'b1; settle();
    chk("R4", IDLE);
    idle_in(); load_e = 1'b1; rd_e = 5'd0; rs1_d = 5'd0; settle();
    chk("R4", IDLE);
  endtask

  task automatic t_we_off_R5();
    idle_in(); rs1_e = 5'd5; rd_m = 5'd5; rs2_e = 5'd9; rd_w = 5'd9; settle();
    chk("R5", IDLE);
  endtask

  task automatic t_load_use_R6();
    idle_in(); load_e = 1'b1; rd_e = 5'd3; rs2_d = 5'd3; settle();
    chk("R6", {2'b00, 2'b00, 5'b00111, 2'b01});
    idle_in(); load_e = 1'b1; rd_e = 5'd14; rs1_d = 5'd14; settle();
    chk("R6", {2'b00, 2'b00, 5'b00111, 2'b01});
  endtask

  task automatic t_non_load_R7();
    idle_in(); rd_e = 5'd3; rs1_d = 5'd3; rs2_d = 5'd3; settle();
    chk("R7", IDLE);
  endtask

  task automatic t_taken_R8();
    idle_in(); taken_e = 1'b1; settle();
    chk("R8", {2'b00, 2'b00, 5'b11111, 2'b11});
    idle_in(); taken_e = 1'b1; load_e = 1'b1; rd_e = 5'd2; settle();
    chk("R8", {2'b00, 2'b00, 5'b00111, 2'b11});
  endtask

  task automatic t_gstall_R9();
    idle_in(); cache_hit = 1'b0; settle();
    chk("R9", {2'b00, 2'b00, 5'b00000, 2'b00});
    idle_in(); mem_ready = 1'b0; settle();
    chk("R9", {2'b00, 2'b00, 5'b00000, 2'b00});
  endtask

  task automatic t_gstall_no_clr_R10();
    idle_in(); mem_ready = 1'b0; taken_e = 1'b1; settle();
    chk("R10", {2'b00, 2'b00, 5'b00000, 2'b00});
    idle_in(); cache_hit = 1'b0; load_e = 1'b1; rd_e = 5'd1; rs1_d = 5'd1; taken_e = 1'b1; settle();
    chk("R10", {2'b00, 2'b00, 5'b00000, 2'b00});
  endtask

  initial begin
    idle_in();
    t_idle_R11();
    t_mem_fwd_R1();
    t_wb_fwd_R2();
    t_prio_R3();
    t_x0_R4();
    t_we_off_R5();
    t_load_use_R6();
    t_non_load_R7();
    t_taken_R8();
    t_gstall_R9();
    t_gstall_no_clr_R10();
    t_idle_R11();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule